// File: doc/BRIEF.md
# Secure Region Access Filter

This block sits on the request path between one bus master and one memory slave. It gives the slave protection even when the slave cannot tell the two security worlds apart. Each read or write carries a one-bit world attribute: 0 marks a secure access and 1 marks a non-secure access. The filter compares the address with a small table of regions, and each region has a base, a size, an enable bit and a secure flag. A non-secure access that lands in a secure region never reaches the slave. Instead the master gets an error response one cycle later, and the processor sees that error as an external abort. Every other access goes to the slave unchanged, with its attribute, and the slave's response comes back unchanged.

The region table is loaded through a separate configuration port. Only a configuration write that carries the secure attribute, and that names an existing region slot, may change the table. Every configuration request gets a response in the next cycle, which reports whether the write was refused. After reset every region is invalid, so all memory stays reachable until secure boot code loads the table.

The master keeps at most one access outstanding. It waits for the response before it issues the next request, and the slave answers a forwarded access in the cycle after it is issued.

Top module: `secure_region_filter`

## Requirements
- R1: After reset all regions are invalid. No response of either port is pending, and a non-secure access to any address is forwarded to the slave.
- R2: A non-secure access (attribute 1) whose address selects a secure region is not forwarded (s_req_valid stays 0). In the next cycle the master sees m_rsp_valid=1 with m_rsp_err=1.
- R3: A blocked read returns all-zero data. A blocked write leaves memory unchanged, which a later secure read of the same address shows.
- R4: A secure access (attribute 0) is always forwarded with its address, data, direction and attribute. The slave's response comes back to the master unchanged.
- R5: A non-secure access is forwarded when its address selects a non-secure region or matches no enabled region.
- R6: When several enabled regions contain the address, the one with the lowest index decides the result.
- R7: A configuration write with attribute 1 leaves the table unchanged. It is answered in the next cycle with cfg_rsp_valid=1 and cfg_rsp_err=1.
- R8: A configuration write with attribute 0 and an index below the region count replaces that region's fields. It is answered in the next cycle with an error-free response, and the new fields govern accesses from the next cycle on.
- R9: A region covers the addresses from base up to, but not including, base plus size. A region of size zero covers no address.
- R10: A configuration write whose index is not below the region count changes nothing and gets an error response.
- R11: A region loaded with its enable bit at 0 matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_req_valid | input | 1 | Master access request |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_ns | input | 1 | World attribute, 1 = non-secure |
| m_req_addr | input | ADDR_W | Access address |
| m_req_wdata | input | DATA_W | Write data |
| m_rsp_valid | output | 1 | Response to master |
| m_rsp_err | output | 1 | Response carries an error |
| m_rsp_rdata | output | DATA_W | Read data to master |
| s_req_valid | output | 1 | Forwarded request to slave |
| s_req_write | output | 1 | Forwarded direction |
| s_req_ns | output | 1 | Forwarded world attribute |
| s_req_addr | output | ADDR_W | Forwarded address |
| s_req_wdata | output | DATA_W | Forwarded write data |
| s_rsp_valid | input | 1 | Slave response |
| s_rsp_err | input | 1 | Slave error |
| s_rsp_rdata | input | DATA_W | Slave read data |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ns | input | 1 | Attribute of the configuration write |
| cfg_idx | input | IDX_W | Region slot to write |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | ADDR_W | Region size in address units |
| cfg_secure | input | 1 | 1 = region is secure |
| cfg_enable | input | 1 | 1 = region takes part in matching |
| cfg_rsp_valid | output | 1 | Configuration response |
| cfg_rsp_err | output | 1 | Configuration write refused |

## Verification
The bench keeps its own copy of the region table and of the slave memory, and predicts on every clock whether a request reaches the slave. Accesses of both attributes are aimed at the inside of a region, at its first and last address, one past its end, and at unmapped space. These tell the attribute check apart from the address compare and expose errors at the boundaries. Overlapping regions are arranged so that a low-index non-secure region hides a higher-index secure one and the reverse, which shows the lowest index deciding. Refused configuration writes (wrong attribute, slot out of range) are followed by accesses whose outcome would change if the table had been touched. Blocked writes are followed by secure read-back.

// File: rtl/sfilt_pkg.sv
// Shared definitions for the secure region access filter.
// Assumes the world attribute is one bit: 0 = secure, 1 = non-secure.
package sfilt_pkg;
    typedef enum logic {
        ATTR_SECURE    = 1'b0,
        ATTR_NONSECURE = 1'b1
    } world_attr_e;
endpackage

// File: rtl/sfilt_region_table.sv
// Region table storage and its configuration port.
// Accepts a write only when it carries the secure attribute and names an
// existing slot; answers every request one cycle later.
// Assumes synchronous active-low reset; reset clears every region.
module sfilt_region_table
    import sfilt_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = $clog2(NUM_REGIONS) + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_valid,
    input  logic                               cfg_ns,
    input  logic [IDX_W-1:0]                   cfg_idx,
    input  logic [ADDR_W-1:0]                  cfg_base,
    input  logic [ADDR_W-1:0]                  cfg_size,
    input  logic                               cfg_secure,
    input  logic                               cfg_enable,
    output logic                               cfg_rsp_valid,
    output logic                               cfg_rsp_err,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_base,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_size,
    output logic [NUM_REGIONS-1:0]             tbl_secure,
    output logic [NUM_REGIONS-1:0]             tbl_enable
);

    logic idx_in_range;
    logic accept;

    // Decide whether the present configuration request may change the table.
    always_comb begin
        idx_in_range = (int'(cfg_idx) < NUM_REGIONS);
        accept       = cfg_valid && (cfg_ns == ATTR_SECURE) && idx_in_range;
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
        // Hold one region's fields; load them on an accepted write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_base[i]   <= '0;
                tbl_size[i]   <= '0;
                tbl_secure[i] <= 1'b0;
                tbl_enable[i] <= 1'b0;
            end else if (accept && (cfg_idx == IDX_W'(i))) begin
                tbl_base[i]   <= cfg_base;
                tbl_size[i]   <= cfg_size;
                tbl_secure[i] <= cfg_secure;
                tbl_enable[i] <= cfg_enable;
            end
        end
    end

    // Answer every configuration request in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rsp_valid <= 1'b0;
            cfg_rsp_err   <= 1'b0;
        end else begin
            cfg_rsp_valid <= cfg_valid;
            cfg_rsp_err   <= cfg_valid && !accept;
        end
    end

endmodule

// File: rtl/sfilt_region_match.sv
// Address-to-region lookup with fixed priority.
// Each enabled region covers [base, base+size). The lowest-index region that
// contains the address decides; no match means non-secure. Purely combinational.
module sfilt_region_match #(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_base,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_size,
    input  logic [NUM_REGIONS-1:0]             tbl_secure,
    input  logic [NUM_REGIONS-1:0]             tbl_enable,
    output logic                               any_hit,
    output logic                               hit_secure
);

    logic [NUM_REGIONS-1:0] hit_vec;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
        logic [ADDR_W:0] offset;
        // Compare the address with one region using a borrow-checked offset.
        always_comb begin
            offset     = {1'b0, addr} - {1'b0, tbl_base[i]};
            hit_vec[i] = tbl_enable[i] && !offset[ADDR_W]
                         && (offset[ADDR_W-1:0] < tbl_size[i]);
        end
    end

    // Pick the lowest-index hit; scanning downward lets it overwrite the others.
    always_comb begin
        any_hit    = |hit_vec;
        hit_secure = 1'b0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_secure = tbl_secure[i];
        end
    end

endmodule

// File: rtl/secure_region_filter.sv
// Top level of the secure region access filter.
// Forwards allowed accesses to the slave in the same cycle and blocks
// non-secure accesses to secure regions. A blocked access gets an error
// response with zero data one cycle later.
// Assumes one outstanding access and a slave that answers one cycle after
// a forwarded request, so a local error never meets a slave response.
module secure_region_filter
    import sfilt_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req_valid,
    input  logic              m_req_write,
    input  logic              m_req_ns,
    input  logic [ADDR_W-1:0] m_req_addr,
    input  logic [DATA_W-1:0] m_req_wdata,
    output logic              m_rsp_valid,
    output logic              m_rsp_err,
    output logic [DATA_W-1:0] m_rsp_rdata,
    output logic              s_req_valid,
    output logic              s_req_write,
    output logic              s_req_ns,
    output logic [ADDR_W-1:0] s_req_addr,
    output logic [DATA_W-1:0] s_req_wdata,
    input  logic              s_rsp_valid,
    input  logic              s_rsp_err,
    input  logic [DATA_W-1:0] s_rsp_rdata,
    input  logic              cfg_valid,
    input  logic              cfg_ns,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_size,
    input  logic              cfg_secure,
    input  logic              cfg_enable,
    output logic              cfg_rsp_valid,
    output logic              cfg_rsp_err
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_base;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] tbl_size;
    logic [NUM_REGIONS-1:0]             tbl_secure;
    logic [NUM_REGIONS-1:0]             tbl_enable;
    logic                               any_hit;
    logic                               hit_secure;
    logic                               deny;
    logic                               blk_rsp_q;

    sfilt_region_table #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W)
    ) table_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_ns        (cfg_ns),
        .cfg_idx       (cfg_idx),
        .cfg_base      (cfg_base),
        .cfg_size      (cfg_size),
        .cfg_secure    (cfg_secure),
        .cfg_enable    (cfg_enable),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_err   (cfg_rsp_err),
        .tbl_base      (tbl_base),
        .tbl_size      (tbl_size),
        .tbl_secure    (tbl_secure),
        .tbl_enable    (tbl_enable)
    );

    sfilt_region_match #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W)
    ) match_i (
        .addr       (m_req_addr),
        .tbl_base   (tbl_base),
        .tbl_size   (tbl_size),
        .tbl_secure (tbl_secure),
        .tbl_enable (tbl_enable),
        .any_hit    (any_hit),
        .hit_secure (hit_secure)
    );

    // Block only non-secure accesses whose deciding region is secure.
    always_comb begin
        deny = m_req_valid && (m_req_ns == ATTR_NONSECURE) && any_hit && hit_secure;
    end

    // Pass allowed requests to the slave with every field unchanged.
    always_comb begin
        s_req_valid = m_req_valid && !deny;
        s_req_write = m_req_write;
        s_req_ns    = m_req_ns;
        s_req_addr  = m_req_addr;
        s_req_wdata = m_req_wdata;
    end

    // Remember a blocked access so it is answered in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_rsp_q <= 1'b0;
        else        blk_rsp_q <= deny;
    end

    // Merge the local error response with the slave's response.
    always_comb begin
        m_rsp_valid = s_rsp_valid || blk_rsp_q;
        m_rsp_err   = s_rsp_err   || blk_rsp_q;
        m_rsp_rdata = blk_rsp_q ? '0 : s_rsp_rdata;
    end

endmodule

// File: rtl/secure_region_filter_chk.sv
// Port-level temporal checks for the secure region access filter, bound to
// every instance of the top module.
module secure_region_filter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_req_valid,
    input logic              m_req_ns,
    input logic              s_req_valid,
    input logic              m_rsp_valid,
    input logic              m_rsp_err,
    input logic [DATA_W-1:0] m_rsp_rdata,
    input logic              cfg_valid,
    input logic              cfg_ns,
    input logic              cfg_rsp_valid,
    input logic              cfg_rsp_err
);

    logic cfg_seen_q;

    // Note whether any secure configuration request has arrived since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cfg_seen_q <= 1'b0;
        else if (cfg_valid && !cfg_ns)   cfg_seen_q <= 1'b1;
    end

    // R1: before any secure configuration, every access reaches the slave.
    assert_open_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_seen_q && m_req_valid) |-> s_req_valid);

    // R2: an access held back from the slave is answered next cycle with an error.
    assert_blocked_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && !s_req_valid) |=> (m_rsp_valid && m_rsp_err));

    // R3: a blocked access returns zero data.
    assert_blocked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && !s_req_valid) |=> (m_rsp_rdata == '0));

    // R4: secure accesses are never held back.
    assert_secure_forwarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && !m_req_ns) |-> s_req_valid);

    // R7: a non-secure configuration write is refused next cycle.
    assert_ns_cfg_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ns) |=> (cfg_rsp_valid && cfg_rsp_err));

    // R8: every configuration request gets exactly one response, one cycle later.
    assert_cfg_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_rsp_valid);
    assert_cfg_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !cfg_rsp_valid);

endmodule

bind secure_region_filter secure_region_filter_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .m_req_valid   (m_req_valid),
    .m_req_ns      (m_req_ns),
    .s_req_valid   (s_req_valid),
    .m_rsp_valid   (m_rsp_valid),
    .m_rsp_err     (m_rsp_err),
    .m_rsp_rdata   (m_rsp_rdata),
    .cfg_valid     (cfg_valid),
    .cfg_ns        (cfg_ns),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_err   (cfg_rsp_err)
);

// File: tb/secure_region_filter_tb.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural region table and memory model, with the
// forwarding decision compared on every clock.
module secure_region_filter_tb_top;

    localparam int NREG = 4;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int IW   = $clog2(NREG) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_req_valid = 0, m_req_write = 0, m_req_ns = 0;
    logic [AW-1:0] m_req_addr = '0;
    logic [DW-1:0] m_req_wdata = '0;
    logic          m_rsp_valid, m_rsp_err;
    logic [DW-1:0] m_rsp_rdata;
    logic          s_req_valid, s_req_write, s_req_ns;
    logic [AW-1:0] s_req_addr;
    logic [DW-1:0] s_req_wdata;
    logic          s_rsp_valid = 0, s_rsp_err = 0;
    logic [DW-1:0] s_rsp_rdata = '0;
    logic          cfg_valid = 0, cfg_ns = 0, cfg_secure = 0, cfg_enable = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0, cfg_size = '0;
    logic          cfg_rsp_valid, cfg_rsp_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference state
    int          ref_base [NREG];
    int          ref_size [NREG];
    bit          ref_sec  [NREG];
    bit          ref_en   [NREG];
    logic [DW-1:0] ref_mem [256];
    logic [DW-1:0] slv_mem [256];

    always #2.5 clk = ~clk;

    secure_region_filter #(.NUM_REGIONS(NREG), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_req_valid(m_req_valid), .m_req_write(m_req_write), .m_req_ns(m_req_ns),
        .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
        .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err), .m_rsp_rdata(m_rsp_rdata),
        .s_req_valid(s_req_valid), .s_req_write(s_req_write), .s_req_ns(s_req_ns),
        .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rsp_err(s_rsp_err), .s_rsp_rdata(s_rsp_rdata),
        .cfg_valid(cfg_valid), .cfg_ns(cfg_ns), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_secure(cfg_secure),
        .cfg_enable(cfg_enable), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err)
    );

    // Slave model: one-cycle response, 256-word memory indexed by address low byte.
    always @(posedge clk) begin
        s_rsp_valid <= s_req_valid;
        s_rsp_err   <= 1'b0;
        if (s_req_valid) begin
            if (s_req_write) slv_mem[s_req_addr[7:0]] <= s_req_wdata;
            else             s_rsp_rdata <= slv_mem[s_req_addr[7:0]];
        end
    end

    function automatic bit model_deny(input logic [AW-1:0] a);
        for (int i = 0; i < NREG; i++) begin
            if (ref_en[i] && int'(a) >= ref_base[i] && int'(a) < ref_base[i] + ref_size[i])
                return ref_sec[i];
        end
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the forwarding decision against the model (R2, R5).
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !finished)
            check("R2", "per-cycle forward decision", 64'(s_req_valid),
                  64'(m_req_valid && !(m_req_ns && model_deny(m_req_addr))));
    end

    task automatic access(input bit wr, input bit ns, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input string req);
        bit dn;
        dn = ns && model_deny(a);
        @(negedge clk);
        m_req_valid = 1; m_req_write = wr; m_req_ns = ns; m_req_addr = a; m_req_wdata = d;
        #1;
        check(req, "forwarded", 64'(s_req_valid), 64'(!dn));
        if (!dn) begin
            check("R4", "fields passed", {s_req_write, s_req_ns, s_req_addr, s_req_wdata},
                  {wr, ns, a, d});
        end
        @(negedge clk);
        m_req_valid = 0;
        #1;
        check(req, "rsp valid", 64'(m_rsp_valid), 64'd1);
        check(req, "rsp err", 64'(m_rsp_err), 64'(dn));
        if (!wr) check(dn ? "R3" : req, "rdata", 64'(m_rsp_rdata),
                       dn ? 64'd0 : 64'(ref_mem[a[7:0]]));
        if (!dn && wr) ref_mem[a[7:0]] = d;
    endtask

    task automatic configure(input bit ns, input int idx, input int base, input int size,
                             input bit sec, input bit en, input string req);
        bit ok;
        ok = !ns && idx < NREG;
        @(negedge clk);
        cfg_valid = 1; cfg_ns = ns; cfg_idx = IW'(idx); cfg_base = AW'(base);
        cfg_size = AW'(size); cfg_secure = sec; cfg_enable = en;
        @(negedge clk);
        cfg_valid = 0;
        #1;
        check(req, "cfg rsp valid", 64'(cfg_rsp_valid), 64'd1);
        check(req, "cfg rsp err", 64'(cfg_rsp_err), 64'(!ok));
        if (ok) begin
            ref_base[idx] = base; ref_size[idx] = size;
            ref_sec[idx] = sec;   ref_en[idx] = en;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; slv_mem[i] = '0; end
        for (int i = 0; i < NREG; i++) begin
            ref_base[i] = 0; ref_size[i] = 0; ref_sec[i] = 0; ref_en[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1", "rsp idle in reset", 64'(m_rsp_valid), 64'd0);
        check("R1", "cfg rsp idle in reset", 64'(cfg_rsp_valid), 64'd0);
        check("R1", "no slave req in reset", 64'(s_req_valid), 64'd0);
        rst_n = 1;

        // R1: open after reset
        access(1, 1, 16'h0110, 32'hA5A5_0001, "R1");
        access(0, 1, 16'h0110, 32'h0, "R1");
        access(1, 1, 16'h0010, 32'h1111_2222, "R1");

        // R8: secure region 0 = [0x0100, 0x0140)
        configure(0, 0, 'h0100, 'h40, 1, 1, "R8");
        access(0, 1, 16'h0110, 32'h0, "R2");
        access(1, 1, 16'h0110, 32'hDEAD_BEEF, "R2");
        access(0, 0, 16'h0110, 32'h0, "R3");
        access(1, 0, 16'h0110, 32'hC0DE_0002, "R4");
        access(0, 0, 16'h0110, 32'h0, "R4");
        access(0, 1, 16'h0010, 32'h0, "R5");

        // R9: boundaries
        access(0, 1, 16'h00FF, 32'h0, "R9");
        access(0, 1, 16'h0100, 32'h0, "R9");
        access(0, 1, 16'h013F, 32'h0, "R9");
        access(0, 1, 16'h0140, 32'h0, "R9");

        // R7: non-secure configuration refused
        configure(1, 1, 'h0200, 'h100, 1, 1, "R7");
        access(0, 1, 16'h0210, 32'h0, "R7");
        configure(1, 0, 'h0100, 'h40, 0, 0, "R7");
        access(0, 1, 16'h0120, 32'h0, "R7");

        // R10: slot out of range refused
        configure(0, 5, 'h0200, 'h100, 1, 1, "R10");
        access(0, 1, 16'h0210, 32'h0, "R10");

        // R6: overlap, lowest index decides
        configure(0, 1, 'h0100, 'h100, 0, 1, "R8");
        configure(0, 2, 'h0180, 'h40, 1, 1, "R8");
        access(0, 1, 16'h0110, 32'h0, "R6");
        access(0, 1, 16'h0190, 32'h0, "R6");
        configure(0, 1, 'h0300, 'h10, 0, 1, "R8");
        access(0, 1, 16'h0190, 32'h0, "R6");

        // R11: disabled region matches nothing
        configure(0, 0, 'h0100, 'h40, 1, 0, "R11");
        access(0, 1, 16'h0110, 32'h0, "R11");

        // R9: zero-size secure region covers nothing
        configure(0, 3, 'h0400, 'h0, 1, 1, "R9");
        access(0, 1, 16'h0400, 32'h0, "R9");

        // R5: non-secure access to unmapped memory
        access(1, 1, 16'h0500, 32'h5555_AAAA, "R5");
        access(0, 1, 16'h0500, 32'h0, "R5");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule